// File: doc/BRIEF.md
# Delay Sweep Training Sequencer

This block walks a memory interface through a grid of coarse and fine delay settings and records how well reads succeed at every point of the grid. It acts as a simple register-bus master: it programs the delay registers, fires a read test through a trigger register, polls a status register for completion, and collects the status words. The result buffer is filled through a dedicated write port, one 32-bit word per grid point. Software or a later stage analyses that buffer to pick the best setting.

A pulse on `start` launches a sweep. The block first wakes the memory path with a single throwaway read of a memory-window address and then stays quiet for a settle time. After that it visits four coarse settings. At each coarse setting it visits sixteen fine settings. Each point runs one priming test and then four measured tests. The status words of the four measured tests are ANDed together into a mask that starts from a fixed seed. The final mask is stored in the result buffer.

Status polls are bounded by timers scaled in nanoseconds. A poll that runs out of time does not stop the sweep: the block raises a sticky flag and carries on. When the last of the 64 entries is stored, `done` pulses and the block returns to idle.

Top module: `sweep_trainer`

## Requirements
- R1: After an accepted start, the first bus transaction is a read of address `WIN_ADDR`. The bus then stays idle for exactly `SETTLE_NS/CLK_NS` cycles before the next transaction.
- R2: Coarse values run from 3 up to 6. Each one is written to `COARSE_ADDR` as `0x02000000 | (coarse * 0x101)`.
- R3: For each coarse value, fine values run from 0 up to 15. Each one is written to `FINE_ADDR` with the 4-bit fine value copied into all eight nibbles.
- R4: Each point starts with a priming test. The block reads `CTRL_ADDR` and writes the same value back with bit 5 set. It then writes `0x80003002` to `TRIG_ADDR` and reads `STAT_ADDR` repeatedly until bit 31 of the status is 1. The status of the priming test is discarded.
- R5: Four measured tests follow the priming test. Each one reads `CTRL_ADDR` and writes it back with bit 5 cleared, writes the same trigger value, and polls the status. The stored entry equals `0x8300FFFF` ANDed with the final status word of each of the four tests.
- R6: Each point stores exactly one entry. `res_we` is high for one cycle. `res_idx` equals `(coarse-3)*16 + fine`, so the index rises by one per point from 0 to 63, with coarse as the outer loop.
- R7: A poll ends on time-out once it has lasted `PRIME_TMO_NS/CLK_NS` cycles (priming test) or `TEST_TMO_NS/CLK_NS` cycles (measured test) without seeing bit 31. The last status read is still used, and `timeout` becomes 1. `timeout` stays 1 until the next accepted start clears it.
- R8: Only one bus transaction is active at a time. `bus_re` and `bus_we` are never high together. Address, data and strobes are held steady until a cycle with `bus_ready` high ends the transaction.
- R9: `done` is high for exactly one cycle, in the same cycle as the store of entry 63. The block then returns to idle. A `start` pulse during a sweep has no effect.
- R10: During and after reset, `done`, `timeout`, `bus_re`, `bus_we` and `res_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a sweep when idle |
| bus_addr | output | 32 | Register-bus address |
| bus_wdata | output | 32 | Register-bus write data |
| bus_we | output | 1 | Write request |
| bus_re | output | 1 | Read request |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Ends the current transaction |
| res_we | output | 1 | Result-buffer write strobe |
| res_idx | output | 6 | Result-buffer entry index |
| res_data | output | 32 | Result-buffer entry value |
| done | output | 1 | One-cycle sweep-complete pulse |
| timeout | output | 1 | Sticky poll time-out flag |

## Verification
Some rules are checked by the assertions on every cycle. These are the exclusive strobes and the stable request while waiting for ready. They also cover the nibble-replicated fine word, the coarse word form, and the trigger value. Finally, they check that `done` is a single pulse tied to entry 63 and that `timeout` only clears on a start. Other behaviour can only be shown by the bench scenarios. This covers the stored ANDed masks under random ready delays and poll lengths, and the coarse-major order. It also covers the exact settle gap after the wake-up read, a forced measured-test time-out that changes one entry, and a start pulse that is ignored in mid-sweep.

// File: rtl/sweep_trainer.sv
module sweep_trainer #(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned SETTLE_NS    = 10000,
  parameter int unsigned PRIME_TMO_NS = 2000000,
  parameter int unsigned TEST_TMO_NS  = 10000,
  parameter logic [31:0] WIN_ADDR     = 32'h0070_0000,
  parameter logic [31:0] COARSE_ADDR  = 32'h0011_11E0,
  parameter logic [31:0] FINE_ADDR    = 32'h0010_0720,
  parameter logic [31:0] CTRL_ADDR    = 32'h0010_0080,
  parameter logic [31:0] TRIG_ADDR    = 32'h0010_053C,
  parameter logic [31:0] STAT_ADDR    = 32'h0010_0560
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic        bus_we,
  output logic        bus_re,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ready,
  output logic        res_we,
  output logic [5:0]  res_idx,
  output logic [31:0] res_data,
  output logic        done,
  output logic        timeout
);
  localparam int unsigned SETTLE_CYC = SETTLE_NS / CLK_NS;
  localparam int unsigned PRIME_CYC  = PRIME_TMO_NS / CLK_NS;
  localparam int unsigned TEST_CYC   = TEST_TMO_NS / CLK_NS;
  localparam logic [31:0] TRIG_WORD  = 32'h8000_3002;
  localparam logic [31:0] ACC_SEED   = 32'h8300_FFFF;

  typedef enum logic [3:0] {
    S_IDLE, S_WAKE, S_SETTLE, S_COARSE, S_FINE,
    S_CRD, S_CWR, S_TRIG, S_POLL, S_STORE
  } st_t;

  st_t         st;
  logic [1:0]  coarse_off;
  logic [3:0]  fine;
  logic [1:0]  test;
  logic        prime;
  logic [31:0] ctrl_q;
  logic [31:0] acc;
  logic [31:0] tmr;
  logic [31:0] poll_lim;
  logic [2:0]  coarse_val;

  assign coarse_val = {1'b0, coarse_off} + 3'd3;
  assign poll_lim   = prime ? PRIME_CYC : TEST_CYC;
  assign bus_re     = (st == S_WAKE) || (st == S_CRD) || (st == S_POLL);
  assign bus_we     = (st == S_COARSE) || (st == S_FINE) || (st == S_CWR) || (st == S_TRIG);
  assign res_we     = (st == S_STORE);
  assign res_idx    = {coarse_off, fine};
  assign res_data   = acc;
  assign done       = (st == S_STORE) && (res_idx == 6'd63);

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_WAKE:   bus_addr = WIN_ADDR;
      S_COARSE: begin
        bus_addr  = COARSE_ADDR;
        bus_wdata = 32'h0200_0000 | ({29'd0, coarse_val} * 32'h101);
      end
      S_FINE: begin
        bus_addr  = FINE_ADDR;
        bus_wdata = {8{fine}};
      end
      S_CRD:    bus_addr = CTRL_ADDR;
      S_CWR: begin
        bus_addr  = CTRL_ADDR;
        bus_wdata = prime ? (ctrl_q | 32'h20) : (ctrl_q & ~32'h20);
      end
      S_TRIG: begin
        bus_addr  = TRIG_ADDR;
        bus_wdata = TRIG_WORD;
      end
      S_POLL:   bus_addr = STAT_ADDR;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; coarse_off <= '0; fine <= '0; test <= '0; prime <= 1'b1;
      ctrl_q <= '0; acc <= '0; tmr <= '0; timeout <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_WAKE; coarse_off <= '0; fine <= '0; prime <= 1'b1; timeout <= 1'b0;
        end
        S_WAKE: if (bus_ready) begin st <= S_SETTLE; tmr <= '0; end
        S_SETTLE: begin
          if (tmr >= SETTLE_CYC - 1) st <= S_COARSE;
          else tmr <= tmr + 32'd1;
        end
        S_COARSE: if (bus_ready) st <= S_FINE;
        S_FINE:   if (bus_ready) st <= S_CRD;
        S_CRD:    if (bus_ready) begin ctrl_q <= bus_rdata; st <= S_CWR; end
        S_CWR:    if (bus_ready) st <= S_TRIG;
        S_TRIG:   if (bus_ready) begin st <= S_POLL; tmr <= '0; end
        S_POLL: begin
          tmr <= tmr + 32'd1;
          if (bus_ready && (bus_rdata[31] || tmr >= poll_lim)) begin
            if (!bus_rdata[31]) timeout <= 1'b1;
            if (prime) begin
              prime <= 1'b0; acc <= ACC_SEED; test <= '0; st <= S_CRD;
            end else begin
              acc <= acc & bus_rdata;
              if (test == 2'd3) st <= S_STORE;
              else begin test <= test + 2'd1; st <= S_CRD; end
            end
          end
        end
        S_STORE: begin
          prime <= 1'b1;
          if (fine == 4'hF) begin
            fine <= '0;
            if (coarse_off == 2'd3) st <= S_IDLE;
            else begin coarse_off <= coarse_off + 2'd1; st <= S_COARSE; end
          end else begin
            fine <= fine + 4'd1; st <= S_FINE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sweep_trainer_chk #(
  parameter logic [31:0] COARSE_ADDR = 32'h0011_11E0,
  parameter logic [31:0] FINE_ADDR   = 32'h0010_0720,
  parameter logic [31:0] TRIG_ADDR   = 32'h0010_053C
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_we,
  input logic        bus_re,
  input logic        bus_ready,
  input logic        res_we,
  input logic [5:0]  res_idx,
  input logic        done,
  input logic        timeout
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && bus_we));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_re || bus_we) && !bus_ready) |=>
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we) && $stable(bus_re)));
  a_r3_fine_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == FINE_ADDR) |-> (bus_wdata == {8{bus_wdata[3:0]}}));
  a_r2_coarse_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == COARSE_ADDR) |->
      (bus_wdata[31:16] == 16'h0200 && bus_wdata[15:8] == bus_wdata[7:0] &&
       bus_wdata[7:0] >= 8'd3 && bus_wdata[7:0] <= 8'd6));
  a_r4_trig_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == TRIG_ADDR) |-> (bus_wdata == 32'h8000_3002));
  a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_we && res_idx == 6'd63));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout) |-> $past(start));
endmodule

bind sweep_trainer sweep_trainer_chk #(
  .COARSE_ADDR(COARSE_ADDR), .FINE_ADDR(FINE_ADDR), .TRIG_ADDR(TRIG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_ready(bus_ready), .res_we(res_we),
  .res_idx(res_idx), .done(done), .timeout(timeout)
);

// File: tb/sweep_trainer_test.sv
module sweep_trainer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE_NS  = 200;
  localparam int SETTLE_CYC = SETTLE_NS / CLK_PERIOD;
  localparam logic [31:0] WIN   = 32'h0070_0000;
  localparam logic [31:0] CRS   = 32'h0011_11E0;
  localparam logic [31:0] FIN   = 32'h0010_0720;
  localparam logic [31:0] CTL   = 32'h0010_0080;
  localparam logic [31:0] TRG   = 32'h0010_053C;
  localparam logic [31:0] STA   = 32'h0010_0560;
  localparam logic [31:0] MSB   = 32'h8000_0000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic bus_we, bus_re, bus_ready = 0;
  logic res_we, done, timeout;
  logic [5:0] res_idx;
  logic [31:0] res_data;

  sweep_trainer #(.CLK_NS(CLK_PERIOD), .SETTLE_NS(SETTLE_NS), .PRIME_TMO_NS(400),
    .TEST_TMO_NS(100)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] key, ctrl_reg, cw, fw;
  int trig_n, polls_left, n_coarse, n_fine, exp_idx, n_done, gap;
  bit in_txn, expect_dummy, gap_on, stall_on;
  int dly, stall_idx;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%08h expected=%08h", req, act, exp); end
  endtask

  function automatic logic [31:0] sv(input int c, input int f, input int k);
    return MSB | (key ^ (c * 32'h9E3779B1) ^ (f * 32'h85EBCA6B) ^ (k * 32'hC2B2AE35));
  endfunction

  function automatic logic [31:0] exp_entry(input int idx, input bit stall);
    logic [31:0] a = 32'h8300_FFFF;
    for (int k = 2; k <= 5; k++) begin
      logic [31:0] v = sv(3 + idx / 16, idx % 16, k);
      if (stall && k == 3) v = v & ~MSB;
      a = a & v;
    end
    return a;
  endfunction

  task automatic serve();
    if (bus_re && bus_addr == WIN) begin
      chk(expect_dummy, "R1 wake read first", bus_addr, WIN);
      expect_dummy = 0; gap_on = 1; gap = 0;
    end else begin
      chk(!expect_dummy, "R1 wake read first", bus_addr, WIN);
      if (bus_we && bus_addr == CRS) begin
        chk(bus_wdata == (32'h0200_0000 | ((3 + n_coarse) * 32'h101)), "R2 coarse word",
            bus_wdata, 32'h0200_0000 | ((3 + n_coarse) * 32'h101));
        n_coarse++; cw = bus_wdata;
      end else if (bus_we && bus_addr == FIN) begin
        chk(bus_wdata == {8{4'(n_fine % 16)}}, "R3 fine word", bus_wdata, {8{4'(n_fine % 16)}});
        n_fine++; fw = bus_wdata; trig_n = 0;
      end else if (bus_re && bus_addr == CTL) begin
        bus_rdata = ctrl_reg;
      end else if (bus_we && bus_addr == CTL) begin
        if (trig_n == 0) chk(bus_wdata == (ctrl_reg | 32'h20), "R4 prime sets bit5", bus_wdata, ctrl_reg | 32'h20);
        else chk(bus_wdata == (ctrl_reg & ~32'h20), "R5 test clears bit5", bus_wdata, ctrl_reg & ~32'h20);
        ctrl_reg = bus_wdata;
      end else if (bus_we && bus_addr == TRG) begin
        chk(bus_wdata == 32'h8000_3002, "R4 trigger word", bus_wdata, 32'h8000_3002);
        trig_n++;
        polls_left = (stall_on && (n_fine - 1) == stall_idx && trig_n == 3) ? 1000000 : int'($urandom % 3);
      end else if (bus_re && bus_addr == STA) begin
        logic [31:0] v = sv(cw[7:0], fw[3:0], trig_n);
        if (polls_left > 0) begin bus_rdata = v & ~MSB; polls_left--; end
        else bus_rdata = v;
      end else chk(0, "R8 unexpected transaction", bus_addr, 0);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin bus_ready = 0; in_txn = 0; end
    else begin
      if (gap_on) begin
        if (!(bus_re || bus_we)) gap++;
        else if (!(bus_re && bus_addr == WIN)) begin
          chk(gap == SETTLE_CYC, "R1 settle gap", gap, SETTLE_CYC); gap_on = 0;
        end
      end
      if (bus_re || bus_we) begin
        if (!in_txn) begin in_txn = 1; dly = $urandom % 3; end
        if (dly == 0) begin bus_ready = 1; in_txn = 0; serve(); end
        else begin dly--; bus_ready = 0; end
      end else bus_ready = 0;
      if (res_we) begin
        chk(res_idx == 6'(exp_idx), "R6 entry index", res_idx, exp_idx);
        chk(res_data == exp_entry(exp_idx, stall_on && exp_idx == stall_idx), "R5 entry value",
            res_data, exp_entry(exp_idx, stall_on && exp_idx == stall_idx));
        chk(trig_n == 5, "R5 five tests per point", trig_n, 5);
        chk(done == (exp_idx == 63), "R9 done with last entry", done, exp_idx == 63);
        exp_idx++;
      end else if (done) chk(0, "R9 done without store", 1, 0);
      if (done) n_done++;
    end
  end

  task automatic sweep(input bit stall, input int sidx, input bit poke);
    stall_on = stall; stall_idx = sidx; n_coarse = 0; n_fine = 0; exp_idx = 0; n_done = 0;
    expect_dummy = 1;
    start = 1; @(negedge clk); start = 0;
    chk(timeout == 0, "R7 flag cleared by start", timeout, 0);
    if (poke) begin
      repeat (400) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (n_done == 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(n_done == 1, "R9 single done", n_done, 1);
    chk(exp_idx == 64, "R6 64 entries", exp_idx, 64);
    chk(n_coarse == 4, "R2 coarse count", n_coarse, 4);
    chk(!bus_re && !bus_we, "R9 idle after done", {bus_re, bus_we}, 0);
    chk(timeout == stall, "R7 timeout flag", timeout, stall);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    key = $urandom; ctrl_reg = $urandom;
    repeat (3) @(negedge clk);
    chk(!done && !timeout && !bus_re && !bus_we && !res_we, "R10 reset state",
        {done, timeout, bus_re, bus_we, res_we}, 0);
    rst_n = 1;
    @(negedge clk);
    sweep(0, 0, 1);
    sweep(1, 5 + int'($urandom % 50), 0);
    key = $urandom;
    sweep(0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule